// File: doc/BRIEF.md
# Flying-Capacitor Balance Time Calculator

This block works out, once per carrier period, how much the durations of the four redundant switching states of a five-level flying-capacitor phase leg should be lengthened or shortened. The aim is to pull the three flying capacitors back to their target voltages without changing the leg's average output voltage.

Each capacitor has its own PI regulator. The regulator acts on the gap between the capacitor's target voltage and its sampled voltage. The regulator result is negated when the load current is negative, which gives one adjust time per capacitor. A fixed zero-sum weighting spreads the three adjust times over the states 1101, 1011, 0111 and 1110. The weighting is chosen so that each capacitor is steered without disturbing the other two. If applying the corrections would make any state's duration negative, all four corrections are shrunk by one common factor. That factor comes from a sequential divider.

A `start` pulse at the period boundary samples every input. The four corrections, in quarter-carrier-tick units, are valid with a one-cycle `done` pulse and are held until the next update.

Top module: `fc_balance_calc`

## Requirements
- R1: The capacitor targets are `vbus>>2`, `vbus>>1` and `(vbus>>1)+(vbus>>2)` for capacitors 1, 2 and 3. Each error is its target minus its sampled voltage.
- R2: On each accepted `start`, the integrator becomes `I + ki*e`, clamped to ±`int_lim` (when enabled). The regulator value is `(kp*e + I_new) >>> 6` (arithmetic shift, rounding toward minus infinity), clamped to ±8191.
- R3: When `i_neg` is 1, each adjust time is the negated regulator value. When `i_neg` is 0, it is the regulator value unchanged.
- R4: In the upper region, the corrections in quarter ticks are:
  - 1101 = −t1+2·t2+t3
  - 1011 = −t1−2·t2+t3
  - 0111 = −t1−2·t2−3·t3
  - 1110 = 3·t1+2·t2+t3
- R5: Whenever no scaling is applied, the four corrections sum to exactly zero.
- R6: The upper region is `mod_ref > 2048`, where `mod_ref` is signed with 12 fraction bits (4096 = 1.0). There the nominal state width is `w = ((4096−mod_ref)*period)>>13`. Outside the upper region, all four corrections are zero.
- R7: If the most negative correction n_min satisfies 4w+n_min < 0, let f = floor(4w·1024/−n_min). Every state whose correction equals n_min gets exactly −4w. Every other state gets sign(n)·((|n|·f)>>10). No output ever makes 4w+correction negative.
- R8: An integrator never leaves the range ±`int_lim`.
- R9: While `enable` is 0, an accepted `start` leaves the integrators unchanged. The proportional path still acts.
- R10: `done` is a one-cycle pulse. It rises 1 clock after the sampling edge when no scaling is needed, and 12 clocks after it when scaling is needed.
- R11: Between `done` pulses the corrections hold their values.
- R12: After reset, the corrections are zero, `done` is 0 and the integrators are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Period-boundary strobe; samples all inputs when idle |
| enable | input | 1 | Integrators update only when 1 |
| i_neg | input | 1 | 1 when the load current is negative |
| vbus | input | 12 | DC bus voltage sample |
| vc1 | input | 12 | Capacitor 1 voltage sample |
| vc2 | input | 12 | Capacitor 2 voltage sample |
| vc3 | input | 12 | Capacitor 3 voltage sample |
| mod_ref | input | 13 | Signed modulation reference, 12 fraction bits |
| period | input | 12 | Carrier period in ticks |
| kp | input | 8 | Proportional gain |
| ki | input | 8 | Integral gain |
| int_lim | input | 23 | Integrator clamp magnitude |
| corr_1101 | output | 17 | Signed correction for state 1101, quarter ticks |
| corr_1011 | output | 17 | Signed correction for state 1011, quarter ticks |
| corr_0111 | output | 17 | Signed correction for state 0111, quarter ticks |
| corr_1110 | output | 17 | Signed correction for state 1110, quarter ticks |
| done | output | 1 | One-cycle pulse when new corrections are valid |

## Verification
A corrupted integrator shows up at the very next update as wrong corrections on all four outputs. It keeps distorting every later period until saturation or reset. A faulty divider quotient appears only on scaled periods, 12 clocks after `start`, as a residual that breaks the exact landing at −4w or the sign of a shrunk correction. A wrong phase-machine state shows within one update as a `done` pulse at the wrong cycle or as outputs changing without `done`.

// File: rtl/fcb_pkg.sv
`timescale 1ns/1ps
// Shared types for the flying-capacitor balance calculator.
// Assumes: state indices below fix the output ordering of the corrections.
package fcb_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MAP  = 2'd1,
        PH_DIV  = 2'd2
    } phase_t;

    localparam int ST_1101 = 0;
    localparam int ST_1011 = 1;
    localparam int ST_0111 = 2;
    localparam int ST_1110 = 3;
    localparam int N_CAP   = 3;
endpackage

// File: rtl/fcb_pi.sv
`timescale 1ns/1ps
// One PI regulator for one flying capacitor.
// Computes error = target - sample, updates a clamped integrator on upd
// (only when en), and registers the signed adjust time, negated when neg.
// Assumes: IW >= GW+VW+2 so the integrator sum cannot wrap.
module fcb_pi #(
    parameter int VW  = 12,
    parameter int GW  = 8,
    parameter int IW  = 24,
    parameter int GSH = 6,
    parameter int TW  = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic                 en,
    input  logic                 neg,
    input  logic [VW-1:0]        ref_v,
    input  logic [VW-1:0]        meas_v,
    input  logic [GW-1:0]        kp,
    input  logic [GW-1:0]        ki,
    input  logic [IW-2:0]        lim,
    output logic signed [TW-1:0] t_adj
);
    localparam int PRW = GW + VW + 2;
    localparam logic signed [IW+1:0] TMAX_W = {{(IW+3-TW){1'b0}}, {(TW-1){1'b1}}};
    localparam logic signed [IW+1:0] TMIN_W = -TMAX_W;

    logic signed [VW:0]     err;
    logic signed [PRW-1:0]  err_x, kp_x, ki_x, p_term, i_term;
    logic signed [IW-1:0]   integ, integ_c, integ_nx;
    logic signed [IW:0]     sum_i, lim_w, nlim_w;
    logic signed [IW+1:0]   pi_sum, sh;
    logic signed [TW-1:0]   tc, t_nx;

    // error and gain products, all operands widened first
    always_comb begin
        err    = $signed({1'b0, ref_v}) - $signed({1'b0, meas_v});
        err_x  = {{(PRW-VW-1){err[VW]}}, err};
        kp_x   = $signed({{(PRW-GW){1'b0}}, kp});
        ki_x   = $signed({{(PRW-GW){1'b0}}, ki});
        p_term = kp_x * err_x;
        i_term = ki_x * err_x;
    end

    // clamped integrator candidate, held when disabled
    always_comb begin
        lim_w  = $signed({2'b00, lim});
        nlim_w = -lim_w;
        sum_i  = $signed({integ[IW-1], integ}) + $signed({{(IW+1-PRW){i_term[PRW-1]}}, i_term});
        if (sum_i > lim_w)       integ_c = IW'(lim_w);
        else if (sum_i < nlim_w) integ_c = IW'(nlim_w);
        else                     integ_c = IW'(sum_i);
        integ_nx = en ? integ_c : integ;
    end

    // regulator output: scale, clamp, apply current sign
    always_comb begin
        pi_sum = $signed({integ_nx[IW-1], integ_nx[IW-1], integ_nx})
               + $signed({{(IW+2-PRW){p_term[PRW-1]}}, p_term});
        sh = pi_sum >>> GSH;
        if (sh > TMAX_W)      tc = TW'(TMAX_W);
        else if (sh < TMIN_W) tc = TW'(TMIN_W);
        else                  tc = TW'(sh);
        t_nx = neg ? -tc : tc;
    end

    // state update on accepted period strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ <= '0;
            t_adj <= '0;
        end else if (upd) begin
            integ <= integ_nx;
            t_adj <= t_nx;
        end
    end

    AST_INT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $past(upd && en) |-> (integ <= $signed({1'b0, $past(lim)}) && integ >= -$signed({1'b0, $past(lim)}))); // R8
    AST_INT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !en) |=> $stable(integ)); // R9
endmodule

// File: rtl/fcb_weights.sv
`timescale 1ns/1ps
// Zero-sum mapping of three adjust times onto four redundant-state
// corrections (quarter-tick units), upper modulation region.
// Assumes: NW >= TW+3 so six times the largest adjust time fits.
module fcb_weights #(
    parameter int TW = 14,
    parameter int NW = 17
) (
    input  logic signed [TW-1:0]  t1,
    input  logic signed [TW-1:0]  t2,
    input  logic signed [TW-1:0]  t3,
    output logic [3:0][NW-1:0]    n_vec
);
    import fcb_pkg::*;
    logic signed [NW-1:0] e1, e2, e3;

    // widen then combine with the fixed weights
    always_comb begin
        e1 = {{(NW-TW){t1[TW-1]}}, t1};
        e2 = {{(NW-TW){t2[TW-1]}}, t2};
        e3 = {{(NW-TW){t3[TW-1]}}, t3};
        n_vec[ST_1101] = -e1 + (e2 <<< 1) + e3;
        n_vec[ST_1011] = -e1 - (e2 <<< 1) + e3;
        n_vec[ST_0111] = -e1 - (e2 <<< 1) - (e3 + (e3 <<< 1));
        n_vec[ST_1110] = (e1 + (e1 <<< 1)) + (e2 <<< 1) + e3;
    end
endmodule

// File: rtl/fcb_div.sv
`timescale 1ns/1ps
// Restoring divider giving QW fraction bits of num/den, one bit per clock.
// Assumes: num < den on go, so the quotient is a pure fraction.
module fcb_div #(
    parameter int AW = 17,
    parameter int QW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] num,
    input  logic [AW-1:0] den,
    output logic [QW-1:0] quo,
    output logic          fin
);
    localparam int CW = $clog2(QW + 1);

    logic [AW:0]   rem;
    logic [AW-1:0] dv;
    logic [CW-1:0] cnt;
    logic          busy;
    logic [AW+1:0] rem_sh, dv_x;
    logic          take;

    // trial subtraction for the next quotient bit
    always_comb begin
        rem_sh = {rem, 1'b0};
        dv_x   = {2'b00, dv};
        take   = (rem_sh >= dv_x);
    end

    // iteration control and quotient shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            dv   <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            quo  <= '0;
            fin  <= 1'b0;
        end else if (go) begin
            rem  <= {1'b0, num};
            dv   <= den;
            cnt  <= CW'(QW);
            busy <= 1'b1;
            quo  <= '0;
            fin  <= 1'b0;
        end else if (busy) begin
            rem  <= (AW+1)'(take ? rem_sh - dv_x : rem_sh);
            quo  <= {quo[QW-2:0], take};
            cnt  <= cnt - 1'b1;
            busy <= (cnt != CW'(1));
            fin  <= (cnt == CW'(1));
        end else begin
            fin  <= 1'b0;
        end
    end

    AST_DIV_REM: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rem < {1'b0, dv})); // R7
    AST_DIV_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin); // R10
endmodule

// File: rtl/fc_balance_calc.sv
`timescale 1ns/1ps
// Per-period balancing corrections for a five-level flying-capacitor leg.
// Samples all inputs on start (when idle), runs three PI regulators, maps
// their adjust times onto four redundant states, and, if a state would go
// negative, shrinks all corrections by a common factor from a divider.
// Assumes: inputs need only be valid on the start cycle; start is ignored
// while a calculation is in flight.
module fc_balance_calc #(
    parameter int VW  = 12,
    parameter int MF  = 12,
    parameter int PW  = 12,
    parameter int GW  = 8,
    parameter int IW  = 24,
    parameter int GSH = 6,
    parameter int TW  = 14,
    parameter int FB  = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 enable,
    input  logic                 i_neg,
    input  logic [VW-1:0]        vbus,
    input  logic [VW-1:0]        vc1,
    input  logic [VW-1:0]        vc2,
    input  logic [VW-1:0]        vc3,
    input  logic signed [MF:0]   mod_ref,
    input  logic [PW-1:0]        period,
    input  logic [GW-1:0]        kp,
    input  logic [GW-1:0]        ki,
    input  logic [IW-2:0]        int_lim,
    output logic signed [TW+2:0] corr_1101,
    output logic signed [TW+2:0] corr_1011,
    output logic signed [TW+2:0] corr_0111,
    output logic signed [TW+2:0] corr_1110,
    output logic                 done
);
    import fcb_pkg::*;

    localparam int MW = MF + 1;
    localparam int NW = TW + 3;
    localparam int XW = MW + PW + 1;
    localparam logic signed [MW-1:0] HALF_M = {2'b01, {(MF-1){1'b0}}};
    localparam logic [MW:0]          ONE_M  = {2'b01, {MF{1'b0}}};

    phase_t                     phase;
    logic                       upd, up_nx, upper_q, norm_q, viol, go, div_fin;
    logic [N_CAP-1:0][VW-1:0]   ref_arr, meas_arr;
    logic [N_CAP-1:0][TW-1:0]   t_arr;
    logic [MW:0]                diff;
    logic [XW-1:0]              prod, w_sh;
    logic [PW-1:0]              w_nx, w_q;
    logic signed [NW-1:0]       w4, n_min;
    logic [3:0][NW-1:0]         n_vec, scaled, corr_q;
    logic [FB-1:0]              quo;

    assign upd = start && (phase == PH_IDLE);

    // capacitor targets and samples, one lane per capacitor
    always_comb begin
        ref_arr[0]  = vbus >> 2;
        ref_arr[1]  = vbus >> 1;
        ref_arr[2]  = (vbus >> 1) + (vbus >> 2);
        meas_arr[0] = vc1;
        meas_arr[1] = vc2;
        meas_arr[2] = vc3;
    end

    genvar g;
    generate
        for (g = 0; g < N_CAP; g++) begin : g_pi
            fcb_pi #(.VW(VW), .GW(GW), .IW(IW), .GSH(GSH), .TW(TW)) u_pi (
                .clk    (clk),
                .rst_n  (rst_n),
                .upd    (upd),
                .en     (enable),
                .neg    (i_neg),
                .ref_v  (ref_arr[g]),
                .meas_v (meas_arr[g]),
                .kp     (kp),
                .ki     (ki),
                .lim    (int_lim),
                .t_adj  (t_arr[g])
            );
        end
    endgenerate

    fcb_weights #(.TW(TW), .NW(NW)) u_wt (
        .t1    ($signed(t_arr[0])),
        .t2    ($signed(t_arr[1])),
        .t3    ($signed(t_arr[2])),
        .n_vec (n_vec)
    );

    // region test and nominal width of each redundant state
    always_comb begin
        up_nx = (mod_ref > HALF_M);
        diff  = ONE_M - {mod_ref[MW-1], mod_ref};
        prod  = {{(XW-MW-1){1'b0}}, diff} * {{(XW-PW){1'b0}}, period};
        w_sh  = prod >> (MF + 1);
        w_nx  = up_nx ? PW'(w_sh) : '0;
    end

    // most negative correction and the non-negativity test
    always_comb begin
        w4    = $signed({{(NW-PW-2){1'b0}}, w_q, 2'b00});
        n_min = $signed(n_vec[0]);
        for (int k = 1; k < 4; k++) begin
            if ($signed(n_vec[k]) < n_min) n_min = $signed(n_vec[k]);
        end
        viol = upper_q && ((w4 + n_min) < $signed(NW'(0)));
        go   = (phase == PH_MAP) && viol;
    end

    fcb_div #(.AW(NW), .QW(FB)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .num   (w4),
        .den   (-n_min),
        .quo   (quo),
        .fin   (div_fin)
    );

    generate
        for (g = 0; g < 4; g++) begin : g_scale
            logic [NW-1:0]    mag_in;
            logic [NW+FB-1:0] mprod;
            logic [NW-1:0]    mag;
            // shrink one correction toward zero by the common factor
            always_comb begin
                mag_in = n_vec[g][NW-1] ? -n_vec[g] : n_vec[g];
                mprod  = {{FB{1'b0}}, mag_in} * {{NW{1'b0}}, quo};
                mag    = NW'(mprod >> FB);
                if ($signed(n_vec[g]) == n_min) scaled[g] = -w4;
                else if (n_vec[g][NW-1])        scaled[g] = -mag;
                else                            scaled[g] = mag;
            end
        end
    endgenerate

    // sequencing: sample, map, optional divide, publish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            upper_q <= 1'b0;
            w_q     <= '0;
            norm_q  <= 1'b0;
            corr_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: if (start) begin
                    upper_q <= up_nx;
                    w_q     <= w_nx;
                    norm_q  <= 1'b0;
                    phase   <= PH_MAP;
                end
                PH_MAP: begin
                    if (!upper_q) begin
                        corr_q <= '0;
                        done   <= 1'b1;
                        phase  <= PH_IDLE;
                    end else if (!viol) begin
                        corr_q <= n_vec;
                        done   <= 1'b1;
                        phase  <= PH_IDLE;
                    end else begin
                        norm_q <= 1'b1;
                        phase  <= PH_DIV;
                    end
                end
                PH_DIV: if (div_fin) begin
                    corr_q <= scaled;
                    done   <= 1'b1;
                    phase  <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign corr_1101 = $signed(corr_q[ST_1101]);
    assign corr_1011 = $signed(corr_q[ST_1011]);
    assign corr_0111 = $signed(corr_q[ST_0111]);
    assign corr_1110 = $signed(corr_q[ST_1110]);

    logic signed [NW+1:0] corr_sum;
    always_comb begin
        corr_sum = {{2{corr_1101[NW-1]}}, corr_1101} + {{2{corr_1011[NW-1]}}, corr_1011}
                 + {{2{corr_0111[NW-1]}}, corr_0111} + {{2{corr_1110[NW-1]}}, corr_1110};
    end

    AST_ZERO_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !norm_q) |-> (corr_sum == '0)); // R5
    AST_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((w4 + corr_1101) >= 0 && (w4 + corr_1011) >= 0
               && (w4 + corr_0111) >= 0 && (w4 + corr_1110) >= 0)); // R7
    AST_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !upper_q) |-> (corr_q == '0)); // R6
    AST_WIDTH_FIT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && up_nx) |-> ((w_sh >> PW) == '0)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(corr_q) || done)); // R11
endmodule

// File: tb/sim_fc_balance_calc.sv
`timescale 1ns/1ps
// Bench: behavioural per-period model, compared with the ports every clock.
module sim_fc_balance_calc;
    localparam int LAT_SCALE = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, enable = 1'b1, i_neg = 1'b0;
    logic [11:0] vbus = '0, vc1 = '0, vc2 = '0, vc3 = '0, period = '0;
    logic signed [12:0] mod_ref = '0;
    logic [7:0] kp = '0, ki = '0;
    logic [22:0] int_lim = '0;
    logic signed [16:0] corr_1101, corr_1011, corr_0111, corr_1110;
    logic done;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    longint integ_m [3];
    longint old_c [4];
    longint new_c [4];

    always #4 clk = ~clk;

    fc_balance_calc u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .enable(enable), .i_neg(i_neg),
        .vbus(vbus), .vc1(vc1), .vc2(vc2), .vc3(vc3), .mod_ref(mod_ref),
        .period(period), .kp(kp), .ki(ki), .int_lim(int_lim),
        .corr_1101(corr_1101), .corr_1011(corr_1011), .corr_0111(corr_0111),
        .corr_1110(corr_1110), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cmp_ports(input string req, input bit exp_done, input bit use_new);
        longint e [4];
        for (int k = 0; k < 4; k++) e[k] = use_new ? new_c[k] : old_c[k];
        chk(done == exp_done, {req, " done"}, longint'(done), longint'(exp_done));
        chk(longint'(corr_1101) == e[0], {req, " corr_1101"}, longint'(corr_1101), e[0]);
        chk(longint'(corr_1011) == e[1], {req, " corr_1011"}, longint'(corr_1011), e[1]);
        chk(longint'(corr_0111) == e[2], {req, " corr_0111"}, longint'(corr_0111), e[2]);
        chk(longint'(corr_1110) == e[3], {req, " corr_1110"}, longint'(corr_1110), e[3]);
    endtask

    // one period: model the expected result, then compare every clock
    task automatic run_case(input int vb, input int v1, input int v2, input int v3,
                            input bit neg, input int m, input int per, input int kpv,
                            input int kiv, input longint limv, input bit en, input string req);
        longint refs [3], meas [3], t [3], n [4];
        longint e, pi, tc, w, w4, nmin, f, mag;
        int lat;
        bit upper;
        refs[0] = vb / 4; refs[1] = vb / 2; refs[2] = vb / 2 + vb / 4;   // R1
        meas[0] = v1; meas[1] = v2; meas[2] = v3;
        for (int c = 0; c < 3; c++) begin
            e = refs[c] - meas[c];
            if (en) begin                                              // R9
                integ_m[c] = integ_m[c] + kiv * e;
                if (integ_m[c] > limv) integ_m[c] = limv;              // R8
                if (integ_m[c] < -limv) integ_m[c] = -limv;
            end
            pi = kpv * e + integ_m[c];                                 // R2
            tc = pi >>> 6;
            if (tc > 8191) tc = 8191;
            if (tc < -8191) tc = -8191;
            t[c] = neg ? -tc : tc;                                     // R3
        end
        n[0] = -t[0] + 2 * t[1] + t[2];                                // R4
        n[1] = -t[0] - 2 * t[1] + t[2];
        n[2] = -t[0] - 2 * t[1] - 3 * t[2];
        n[3] = 3 * t[0] + 2 * t[1] + t[2];
        upper = (m > 2048);                                            // R6
        w = upper ? (((4096 - m) * per) >> 13) : 0;
        w4 = 4 * w;
        nmin = n[0];
        for (int k = 1; k < 4; k++) if (n[k] < nmin) nmin = n[k];
        lat = 1;
        if (!upper) begin
            for (int k = 0; k < 4; k++) new_c[k] = 0;
        end else if (w4 + nmin >= 0) begin
            for (int k = 0; k < 4; k++) new_c[k] = n[k];
        end else begin                                                 // R7
            lat = LAT_SCALE;
            f = (w4 * 1024) / (-nmin);
            for (int k = 0; k < 4; k++) begin
                mag = ((n[k] < 0 ? -n[k] : n[k]) * f) >> 10;
                if (n[k] == nmin) new_c[k] = -w4;
                else new_c[k] = (n[k] < 0) ? -mag : mag;
            end
        end
        @(negedge clk);
        vbus = 12'(vb); vc1 = 12'(v1); vc2 = 12'(v2); vc3 = 12'(v3);
        i_neg = neg; mod_ref = 13'(m); period = 12'(per);
        kp = 8'(kpv); ki = 8'(kiv); int_lim = 23'(limv); enable = en;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cmp_ports({req, " R10 pre"}, 1'b0, 1'b0);
        for (int k = 1; k <= lat + 1; k++) begin
            @(negedge clk);
            cmp_ports({req, (k == lat) ? " R10 done" : " R11 hold"}, (k == lat), (k >= lat));
        end
        for (int k = 0; k < 4; k++) old_c[k] = new_c[k];
    endtask

    initial begin
        for (int c = 0; c < 3; c++) integ_m[c] = 0;
        for (int k = 0; k < 4; k++) begin old_c[k] = 0; new_c[k] = 0; end
        repeat (3) @(negedge clk);
        cmp_ports("R12 reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_ports("R12 after reset", 1'b0, 1'b0);

        run_case(2000, 480, 1010, 1490, 1'b0, 3000, 1000, 16, 4, 100000, 1'b1, "R4 R1 R5 base");
        run_case(2000, 480, 1010, 1490, 1'b1, 3000, 1000, 16, 4, 100000, 1'b1, "R3 negative current");
        run_case(2000, 530, 960, 1520, 1'b0, 3500, 1000, 16, 4, 100000, 1'b1, "R2 R4 mixed errors");
        run_case(2000, 480, 1010, 1490, 1'b0, 0, 1000, 16, 4, 100000, 1'b1, "R6 mid region");
        run_case(2000, 480, 1010, 1490, 1'b0, -3000, 1000, 16, 4, 100000, 1'b1, "R6 low region");
        run_case(2000, 480, 1010, 1490, 1'b0, 2048, 1000, 16, 4, 100000, 1'b1, "R6 boundary");
        run_case(2000, 480, 1010, 1490, 1'b0, 2049, 1000, 16, 4, 100000, 1'b1, "R6 just upper");
        run_case(2000, 0, 1000, 1500, 1'b0, 4000, 1000, 16, 4, 100000, 1'b1, "R7 scale cap1");
        run_case(2000, 500, 1000, 3000, 1'b0, 3900, 1000, 16, 4, 100000, 1'b1, "R7 scale cap3");
        run_case(2000, 500, 1500, 1500, 1'b1, 3800, 2000, 20, 6, 100000, 1'b1, "R7 scale cap2");
        repeat (3) run_case(2000, 100, 200, 300, 1'b0, 3000, 1000, 2, 200, 5000, 1'b1, "R8 saturation");
        repeat (2) run_case(2000, 450, 1100, 1400, 1'b0, 3000, 1000, 16, 4, 100000, 1'b0, "R9 disabled");
        run_case(2000, 450, 1100, 1400, 1'b0, 3000, 1000, 16, 4, 100000, 1'b1, "R9 re-enabled");
        repeat (5) begin
            @(negedge clk);
            cmp_ports("R11 idle hold", 1'b0, 1'b0);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule